// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Disable

This block watches for a stalled program. A down-counter advances on system tick cycles. When it runs out without being restarted, the block raises a reset request for one clock and reloads itself. Software restarts the counter by issuing a restart command.

The watchdog comes up enabled after power-on reset. It is enabled again every time the system comes back from its low-power backup state, even if software had turned it off before entering backup.

Software can switch the watchdog off in only one way. It issues the disable command, and the next instruction it issues must be a restart. A disable command arms the block for exactly one instruction. Idle cycles, where no instruction strobe is high, do not use up that slot. Any other instruction in that slot leaves the watchdog running. The state of the enable flag is visible on an output.

Top module: `wdog_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `wdt_enabled` is 1 and `rst_req` is 0.
- R2: The counter advances only on clock edges where `tick_en` is 1 and the watchdog is enabled. `rst_req` goes high right after the edge that samples the TIMEOUT-th such tick counted from the last reload.
- R3: `rst_req` is high for exactly one cycle. The counter then reloads, and the next request follows after another TIMEOUT ticks.
- R4: `cmd_restart` on its own reloads the counter to a full TIMEOUT ticks, whether or not a tick arrives in the same cycle. It leaves `wdt_enabled` unchanged.
- R5: `cmd_disable` followed by `cmd_restart` as the next instruction strobe clears `wdt_enabled` to 0. While the flag is 0, `rst_req` stays 0 whatever the ticks.
- R6: `cmd_disable` followed by a `cmd_other` strobe leaves `wdt_enabled` at 1, and a `cmd_restart` after that only reloads the counter.
- R7: Cycles with no instruction strobe between `cmd_disable` and `cmd_restart` do not break the sequence. The armed state ends at the next strobe of any kind.
- R8: `backup_exit` sets `wdt_enabled` to 1, reloads the counter and clears the armed state. It takes priority over any command strobe in the same cycle.
- R9: Reset clears the armed state, so a restart issued after reset does not disable the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable from the time base |
| cmd_disable | input | 1 | Disable-command instruction strobe |
| cmd_restart | input | 1 | Restart-command instruction strobe |
| cmd_other | input | 1 | Strobe for any other executed instruction |
| backup_exit | input | 1 | One-cycle pulse on return from backup |
| rst_req | output | 1 | One-cycle reset request on expiry |
| wdt_enabled | output | 1 | Watchdog enable flag |

## Verification
Both outputs are registered. A strobe or tick sampled at one rising edge shows its effect on `rst_req` and `wdt_enabled` right after that same edge, so the result is due one edge after the stimulus is driven. The bench drives inputs on the falling edge and waits for the rising edge. It then compares both outputs one time unit later against a cycle model written from the requirements. That model tracks the ticks left, the flag and the armed state.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // One instruction slot worth of command strobes
    typedef struct packed {
        logic dis;
        logic rst;
        logic oth;
    } cmd_t;

    // Sequencer state
    typedef struct packed {
        logic en;
        logic armed;
    } ctl_state_t;

endpackage

// File: rtl/wdg_arm_ctl.sv
module wdg_arm_ctl
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic backup,
    output logic en,
    output logic armed
);

    ctl_state_t st_d, st_q;
    logic       any_instr;

    always_comb begin
        st_d      = st_q;
        any_instr = cmd.dis | cmd.rst | cmd.oth;
        if (backup) begin
            st_d.en    = 1'b1;
            st_d.armed = 1'b0;
        end else begin
            if (st_q.armed && cmd.rst) begin
                st_d.en = 1'b0;
            end
            if (cmd.dis) begin
                st_d.armed = 1'b1;
            end else if (any_instr) begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b1, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en    = st_q.en;
    assign armed = st_q.armed;

    // R8
    backup_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup |=> en);

    // R5
    seq_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cmd.rst && !backup) |=> !en);

    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && !(armed && cmd.rst)) |=> $stable(en));

    // R7
    arm_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd.rst || cmd.oth) && !cmd.dis) |=> !armed);

endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
    parameter int unsigned TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    input  logic tick,
    output logic req
);

    localparam int unsigned CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TIMEOUT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (reload) begin
            st_d.cnt = LOAD;
        end else if (run && tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = LOAD;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: LOAD, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R4
    reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !req);

    // R2
    no_tick_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !req);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int unsigned TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic cmd_disable,
    input  logic cmd_restart,
    input  logic cmd_other,
    input  logic backup_exit,
    output logic rst_req,
    output logic wdt_enabled
);
    import wdg_pkg::*;

    cmd_t cmd;
    logic en_w;
    logic armed_w;
    logic reload_w;

    assign cmd      = '{dis: cmd_disable, rst: cmd_restart, oth: cmd_other};
    assign reload_w = cmd_restart | backup_exit;

    wdg_arm_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .backup (backup_exit),
        .en     (en_w),
        .armed  (armed_w)
    );

    wdg_down_cnt #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_w),
        .reload (reload_w),
        .tick   (tick_en),
        .req    (rst_req)
    );

    assign wdt_enabled = en_w;

    // R5
    off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_enabled && !backup_exit) |=> !rst_req);

    // R9
    reset_unarmed_chk: assert property (@(posedge clk)
        !rst_n |=> !armed_w);

endmodule

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;
    localparam int unsigned TO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, cmd_disable = 1'b0, cmd_restart = 1'b0;
    logic cmd_other = 1'b0, backup_exit = 1'b0;
    logic rst_req, wdt_enabled;

    int checks = 0, failures = 0, cycles = 0;
    string tag = "R1";

    int  m_left;
    bit  m_en, m_armed, m_req;

    always #10 clk = ~clk;

    wdog_guard #(.TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cmd_disable(cmd_disable), .cmd_restart(cmd_restart),
        .cmd_other(cmd_other), .backup_exit(backup_exit),
        .rst_req(rst_req), .wdt_enabled(wdt_enabled)
    );

    task automatic chk(string t, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", t, what, got, exp);
        end
    endtask

    // Cycle model written from the requirements
    function automatic void model_step(bit d, bit r, bit o, bit b, bit t);
        bit en0 = m_en, arm0 = m_armed;
        m_req = 1'b0;
        if (b) begin
            m_en = 1'b1; m_armed = 1'b0; m_left = TO;
        end else begin
            if (arm0 && r) m_en = 1'b0;
            if (d) m_armed = 1'b1;
            else if (r || o) m_armed = 1'b0;
            if (r) m_left = TO;
            else if (en0 && t) begin
                m_left--;
                if (m_left == 0) begin
                    m_req = 1'b1; m_left = TO;
                end
            end
        end
    endfunction

    task automatic step(bit d, bit r, bit o, bit b, bit t);
        @(negedge clk);
        cmd_disable = d; cmd_restart = r; cmd_other = o;
        backup_exit = b; tick_en = t;
        @(posedge clk);
        model_step(d, r, o, b, t);
        #1;
        chk(tag, rst_req, m_req, "rst_req");
        chk(tag, wdt_enabled, m_en, "wdt_enabled");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cmd_disable, cmd_restart, cmd_other, backup_exit, tick_en} = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", wdt_enabled, 1'b1, "wdt_enabled in reset");
        chk("R1", rst_req, 1'b0, "rst_req in reset");
        @(negedge clk);
        rst_n = 1'b1;
        m_en = 1'b1; m_armed = 1'b0; m_left = TO; m_req = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        tag = "R1";
        step(0, 0, 0, 0, 0);

        // R2: ticks with idle gaps; expiry on the TO-th tick
        tag = "R2";
        for (int i = 0; i < TO - 1; i++) begin
            step(0, 0, 0, 0, 1);
            step(0, 0, 0, 0, 0);
        end
        step(0, 0, 0, 0, 1);
        chk("R2", rst_req, 1'b1, "expiry on TO-th tick");

        // R3: single-cycle pulse then a second full period
        tag = "R3";
        step(0, 0, 0, 0, 1);
        chk("R3", rst_req, 1'b0, "pulse width one cycle");
        ticks(TO - 2);
        step(0, 0, 0, 0, 1);
        chk("R3", rst_req, 1'b1, "second expiry");

        // R4: restart with a tick in the same cycle reloads
        tag = "R4";
        ticks(8);
        step(0, 1, 0, 0, 1);
        ticks(TO - 1);
        chk("R4", rst_req, 1'b0, "no expiry before full period");
        step(0, 0, 0, 0, 1);
        chk("R4", rst_req, 1'b1, "expiry after restart");
        chk("R4", wdt_enabled, 1'b1, "flag kept");

        // R6: disable, other, restart keeps running
        tag = "R6";
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 1, 0, 0, 0);
        chk("R6", wdt_enabled, 1'b1, "broken sequence");

        // R7: idle cycles do not break the sequence
        tag = "R7";
        step(1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0);
        chk("R7", wdt_enabled, 1'b0, "disable across idle");

        // R5: disabled watchdog never requests
        tag = "R5";
        ticks(3 * TO);
        chk("R5", rst_req, 1'b0, "no request while off");
        chk("R5", wdt_enabled, 1'b0, "stays off");

        // R8: backup exit re-enables and reloads
        tag = "R8";
        step(0, 0, 0, 1, 1);
        chk("R8", wdt_enabled, 1'b1, "re-enabled");
        ticks(TO - 1);
        step(0, 0, 0, 0, 1);
        chk("R8", rst_req, 1'b1, "expiry after backup exit");
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 1, 0);
        chk("R8", wdt_enabled, 1'b1, "backup beats restart");
        step(0, 1, 0, 0, 0);
        chk("R8", wdt_enabled, 1'b1, "armed state cleared");

        // R9: reset clears the armed state
        tag = "R9";
        step(1, 0, 0, 0, 0);
        do_reset();
        step(0, 1, 0, 0, 0);
        chk("R9", wdt_enabled, 1'b1, "restart after reset");

        // Random mix, tagged to the counting requirement
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int unsigned sel = $urandom_range(0, 99);
            bit d = (sel < 8);
            bit r = (sel >= 8 && sel < 16);
            bit o = (sel >= 16 && sel < 30);
            bit b = ($urandom_range(0, 199) == 0);
            bit t = $urandom_range(0, 1) == 1;
            step(d, r, o, b, t);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule